// File: doc/BRIEF.md
# Command-Driven UART Transmit Engine

This block serialises characters onto a single asynchronous serial line. Software first fills a transmit FIFO of 32-bit words. It then loads a transfer length and issues a transmit command. The engine takes bytes out of the FIFO words, starting at bits 7:0 and moving up to the programmed number of bytes per word. It frames each byte with a start bit, the configured number of data bits sent least significant bit first, an optional parity bit and a stop period. After exactly the programmed number of characters it stops and raises a command-done status bit.

The line idles high. Timing comes from a divider that produces oversample ticks, and one bit time is 32 ticks. Two further commands drive the line low for a break and release it. A running command can be cancelled, which ends it cleanly at the next character boundary, or aborted, which ends it at once. An optional clear-to-send input holds back each new character until the far end is ready. Four sticky status bits report command completion, cancel completion, abort completion and a low FIFO fill level. Each bit is cleared by writing 1 to its position.

The FIFO write port is valid/ready. A word is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` depends only on the fill level, never on `wr_valid`, and it falls only when the FIFO is full. A producer that sees ready low keeps its word and holds valid until ready returns.

Top module: `uart_tx_engine`

## Requirements
- R1: Opcode 1 on `cmd_op`, with `cmd_valid` high while idle, sends exactly `trans_len` characters. It then sets status bit 0 (command done). With a length of 0 it sets bit 0 and sends nothing. FIFO words beyond the last one needed are left in place.
- R2: Each character is one low start bit, then the data bits least significant first, then the stop period. The word-length field gives the number of data bits: values 5 to 8 are used as given, values below 5 act as 5 and values above 8 act as 8. The line is high whenever no frame or break is in progress.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_mode` selects it: 0 gives even parity over the data bits, 1 gives odd, 2 gives a constant 0 and 3 gives a constant 1. When `cfg_par_en` is 0 there is no parity bit.
- R4: One bit lasts 32 oversample ticks, and a tick comes every `cfg_clk_div` clock cycles, with 0 acting as 1. The stop period is 32 ticks for code 0, 48 for code 1 and 64 for codes 2 and 3. While data is available, the next start bit follows the stop period with no gap.
- R5: When `busy` is low, `txd` is high.
- R6: When `cfg_cts_mask` is 0, no new character starts while `cts` is low. When it is 1, `cts` has no effect.
- R7: `cfg_bytes_per_word` sets how many bytes each FIFO word yields, from 1 to 4. A value of 0 acts as 1. Bytes are taken from bits 7:0 upward. At the last character of a command the current word is released, and any bytes left in it are discarded.
- R8: Opcode 4 while idle drives `txd` low and sets `busy`. Opcode 5 during a break releases the line and sets bit 0. Opcode 5 when no break is active, and opcodes other than 1, 4 and 5, have no effect.
- R9: The FIFO holds 16 words. `fifo_level` counts the stored words, and `wr_ready` is low exactly when the FIFO is full. A write offered while the FIFO is full is not stored.
- R10: Status bit 3 is set in every cycle where `fifo_level` is less than or equal to `cfg_watermark`.
- R11: A cancel request lets the character in flight finish. The command then ends with status bit 1 (cancel done), without bit 0, and no further FIFO word is consumed. A cancel request while idle sets bit 1 at once.
- R12: An abort request ends any transfer or break at once: in the next cycle `busy` is low, `txd` is high and status bit 2 (abort done) is set.
- R13: Status bits are sticky. Writing 1 to a bit position of `irq_clear` clears that bit, unless its set condition holds in the same cycle. Bits written 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | FIFO write word valid |
| wr_ready | output | 1 | FIFO can accept a word |
| wr_data | input | 32 | FIFO write word |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 4 | Command opcode (1 transmit, 4 break on, 5 break off) |
| trans_len | input | 24 | Characters to send, sampled with the transmit command |
| cancel_req | input | 1 | Cancel at the next character boundary, one cycle |
| abort_req | input | 1 | Abort immediately, one cycle |
| cfg_word_len | input | 10 | Data bits per character |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_mode | input | 2 | Parity kind: 0 even, 1 odd, 2 zero, 3 one |
| cfg_stop_len | input | 2 | Stop code: 0 one bit, 1 one and a half, 2 two |
| cfg_cts_mask | input | 1 | Ignore clear-to-send when 1 |
| cfg_clk_div | input | 16 | Clock cycles per oversample tick |
| cfg_bytes_per_word | input | 3 | Bytes taken from each FIFO word |
| cfg_watermark | input | 5 | Low-fill threshold, typically 2 |
| cts | input | 1 | Clear to send, active high |
| irq_clear | input | 4 | Write-one-to-clear for the status bits |
| irq_status | output | 4 | Status: 0 done, 1 cancel done, 2 abort done, 3 low fill |
| fifo_level | output | 5 | Words held in the FIFO |
| busy | output | 1 | A transfer or break is active |
| txd | output | 1 | Serial output line |

## Verification
A wrong byte index or word-release decision shows up as data arriving in the wrong order, or as a wrong `fifo_level` once the command has finished. Both are visible within one character time of the fault. A wrong bit or tick count stretches or shortens the distance between consecutive start edges, which the bench measures to the cycle in each frame configuration. A stuck cancel or abort flag shows up as a missing or wrong status bit, or as an extra character on the line, within one frame of the request.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam logic [3:0] OP_TX     = 4'd1;
  localparam logic [3:0] OP_BRK_ON = 4'd4;
  localparam logic [3:0] OP_BRK_OFF= 4'd5;

  localparam int OS_RATE  = 32;

  localparam int SB_DONE   = 0;
  localparam int SB_CANCEL = 1;
  localparam int SB_ABORT  = 2;
  localparam int SB_LOWFILL= 3;
  localparam int N_STAT    = 4;

  typedef enum logic [2:0] {
    F_IDLE, F_GAP, F_START, F_DATA, F_PAR, F_STOP, F_BREAK
  } frm_e;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_ZERO  = 2'd2,
    PAR_ONE   = 2'd3
  } par_e;
endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // a divider of zero behaves like one
  assign last = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          push, pop;

  assign wr_ready = (cnt < LW'(DEPTH));
  assign empty    = (cnt == '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_en && !empty;
  assign rd_data  = mem[rp];
  assign level    = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [LEN_W-1:0] trans_len,
  input  logic             cancel_req,
  input  logic             abort_req,
  input  logic [9:0]       cfg_word_len,
  input  logic             cfg_par_en,
  input  logic [1:0]       cfg_par_mode,
  input  logic [1:0]       cfg_stop_len,
  input  logic             cfg_cts_mask,
  input  logic [2:0]       cfg_bytes_per_word,
  input  logic             cts,
  input  logic             fifo_empty,
  input  logic [W-1:0]     fifo_word,
  output logic             pop,
  output logic             txd,
  output logic             busy,
  output logic             ev_done,
  output logic             ev_cancel,
  output logic             ev_abort
);
  localparam int BPW_MAX = W / 8;
  localparam int IDX_W   = (BPW_MAX > 1) ? $clog2(BPW_MAX) : 1;

  frm_e             state, state_n;
  logic [LEN_W-1:0] rem, rem_n;
  logic [IDX_W-1:0] bidx, bidx_n;
  logic [7:0]       shreg, shreg_n;
  logic [2:0]       bit_idx, bit_idx_n;
  logic [6:0]       os_cnt, os_cnt_n;
  logic             par_bit, par_bit_n;
  logic             cxl_pend, cxl_pend_n;

  // configuration decode
  logic [3:0]       nbits;
  logic [6:0]       stop_ticks;
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       dmask, cur_byte, new_char;
  logic             new_par, can_launch, bit_end, boundary;

  always_comb begin
    if (cfg_word_len < 10'd5)      nbits = 4'd5;
    else if (cfg_word_len > 10'd8) nbits = 4'd8;
    else                           nbits = cfg_word_len[3:0];
  end

  always_comb begin
    case (cfg_stop_len)
      2'd0:    stop_ticks = 7'd32;
      2'd1:    stop_ticks = 7'd48;
      default: stop_ticks = 7'd64;
    endcase
  end

  always_comb begin
    if (cfg_bytes_per_word == 3'd0)                 last_idx = '0;
    else if (int'(cfg_bytes_per_word) > BPW_MAX)    last_idx = IDX_W'(BPW_MAX-1);
    else                                            last_idx = IDX_W'(cfg_bytes_per_word - 3'd1);
  end

  assign dmask    = 8'hFF >> (4'd8 - nbits);
  assign cur_byte = fifo_word[{bidx, 3'b000} +: 8];
  assign new_char = cur_byte & dmask;

  always_comb begin
    case (par_e'(cfg_par_mode))
      PAR_EVEN: new_par = ^new_char;
      PAR_ODD:  new_par = ~^new_char;
      PAR_ZERO: new_par = 1'b0;
      default:  new_par = 1'b1;
    endcase
  end

  assign can_launch = !fifo_empty && (cts || cfg_cts_mask);
  assign bit_end    = (os_cnt == 7'(OS_RATE-1));

  always_comb begin
    state_n    = state;
    rem_n      = rem;
    bidx_n     = bidx;
    shreg_n    = shreg;
    bit_idx_n  = bit_idx;
    os_cnt_n   = os_cnt;
    par_bit_n  = par_bit;
    cxl_pend_n = cxl_pend;
    pop        = 1'b0;
    ev_done    = 1'b0;
    ev_cancel  = 1'b0;
    ev_abort   = 1'b0;
    boundary   = 1'b0;

    if (abort_req) begin
      state_n    = F_IDLE;
      cxl_pend_n = 1'b0;
      ev_abort   = 1'b1;
    end else begin
      case (state)
        F_IDLE: begin
          if (cancel_req) begin
            ev_cancel = 1'b1;
          end else if (cmd_valid && cmd_op == OP_TX) begin
            state_n    = F_GAP;
            rem_n      = trans_len;
            bidx_n     = '0;
            cxl_pend_n = 1'b0;
          end else if (cmd_valid && cmd_op == OP_BRK_ON) begin
            state_n = F_BREAK;
          end
        end
        F_BREAK: begin
          if (cancel_req) begin
            state_n   = F_IDLE;
            ev_cancel = 1'b1;
          end else if (cmd_valid && cmd_op == OP_BRK_OFF) begin
            state_n = F_IDLE;
            ev_done = 1'b1;
          end
        end
        default: begin
          if (cancel_req) cxl_pend_n = 1'b1;
          if (tick) begin
            case (state)
              F_GAP: boundary = 1'b1;
              F_START: begin
                if (bit_end) begin
                  state_n   = F_DATA;
                  os_cnt_n  = '0;
                  bit_idx_n = '0;
                end else os_cnt_n = os_cnt + 1'b1;
              end
              F_DATA: begin
                if (bit_end) begin
                  os_cnt_n = '0;
                  if ({1'b0, bit_idx} == nbits - 4'd1)
                    state_n = cfg_par_en ? F_PAR : F_STOP;
                  else begin
                    shreg_n   = shreg >> 1;
                    bit_idx_n = bit_idx + 1'b1;
                  end
                end else os_cnt_n = os_cnt + 1'b1;
              end
              F_PAR: begin
                if (bit_end) begin
                  state_n  = F_STOP;
                  os_cnt_n = '0;
                end else os_cnt_n = os_cnt + 1'b1;
              end
              F_STOP: begin
                if (os_cnt == stop_ticks - 7'd1) boundary = 1'b1;
                else os_cnt_n = os_cnt + 1'b1;
              end
              default: state_n = F_IDLE;
            endcase
          end

          // decision taken at each character boundary
          if (boundary) begin
            if (cxl_pend || cancel_req) begin
              state_n    = F_IDLE;
              cxl_pend_n = 1'b0;
              ev_cancel  = 1'b1;
            end else if (rem == '0) begin
              state_n = F_IDLE;
              ev_done = 1'b1;
            end else if (can_launch) begin
              state_n   = F_START;
              os_cnt_n  = '0;
              shreg_n   = new_char;
              par_bit_n = new_par;
              rem_n     = rem - 1'b1;
              if (bidx == last_idx || rem == LEN_W'(1)) begin
                pop    = 1'b1;
                bidx_n = '0;
              end else begin
                bidx_n = bidx + 1'b1;
              end
            end else begin
              state_n = F_GAP;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= F_IDLE;
      rem      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      os_cnt   <= '0;
      par_bit  <= 1'b0;
      cxl_pend <= 1'b0;
    end else begin
      state    <= state_n;
      rem      <= rem_n;
      bidx     <= bidx_n;
      shreg    <= shreg_n;
      bit_idx  <= bit_idx_n;
      os_cnt   <= os_cnt_n;
      par_bit  <= par_bit_n;
      cxl_pend <= cxl_pend_n;
    end
  end

  always_comb begin
    case (state)
      F_START: txd = 1'b0;
      F_DATA:  txd = shreg[0];
      F_PAR:   txd = par_bit;
      F_BREAK: txd = 1'b0;
      default: txd = 1'b1;
    endcase
  end

  assign busy = (state != F_IDLE);
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import utx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_W     = 32,
  parameter int LEN_W      = 24,
  parameter int DIV_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [LEN_W-1:0]  trans_len,
  input  logic              cancel_req,
  input  logic              abort_req,
  input  logic [9:0]        cfg_word_len,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_mode,
  input  logic [1:0]        cfg_stop_len,
  input  logic              cfg_cts_mask,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [2:0]        cfg_bytes_per_word,
  input  logic [LVL_W-1:0]  cfg_watermark,
  input  logic              cts,
  input  logic [N_STAT-1:0] irq_clear,
  output logic [N_STAT-1:0] irq_status,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              busy,
  output logic              txd
);
  logic              tick;
  logic              pop, fifo_empty;
  logic [WORD_W-1:0] fifo_word;
  logic              ev_done, ev_cancel, ev_abort;
  logic [N_STAT-1:0] stat_set;

  utx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (cfg_clk_div),
    .tick (tick)
  );

  utx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (fifo_word),
    .empty   (fifo_empty),
    .level   (fifo_level)
  );

  utx_framer #(.LEN_W(LEN_W), .W(WORD_W)) u_framer (
    .clk               (clk),
    .rst_n             (rst_n),
    .tick              (tick),
    .cmd_valid         (cmd_valid),
    .cmd_op            (cmd_op),
    .trans_len         (trans_len),
    .cancel_req        (cancel_req),
    .abort_req         (abort_req),
    .cfg_word_len      (cfg_word_len),
    .cfg_par_en        (cfg_par_en),
    .cfg_par_mode      (cfg_par_mode),
    .cfg_stop_len      (cfg_stop_len),
    .cfg_cts_mask      (cfg_cts_mask),
    .cfg_bytes_per_word(cfg_bytes_per_word),
    .cts               (cts),
    .fifo_empty        (fifo_empty),
    .fifo_word         (fifo_word),
    .pop               (pop),
    .txd               (txd),
    .busy              (busy),
    .ev_done           (ev_done),
    .ev_cancel         (ev_cancel),
    .ev_abort          (ev_abort)
  );

  always_comb begin
    stat_set             = '0;
    stat_set[SB_DONE]    = ev_done;
    stat_set[SB_CANCEL]  = ev_cancel;
    stat_set[SB_ABORT]   = ev_abort;
    stat_set[SB_LOWFILL] = (fifo_level <= cfg_watermark);
  end

  // sticky status, set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) irq_status <= '0;
    else        irq_status <= (irq_status & ~irq_clear) | stat_set;
  end
endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [LVL_W-1:0] fifo_level,
  input logic             busy,
  input logic             txd,
  input logic             abort_req,
  input logic [3:0]       irq_status
);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  a_r9_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (fifo_level <= $past(fifo_level)));

  a_r9_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !busy) |=> (fifo_level == $past(fifo_level) + 1'b1));

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r12_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy && txd && irq_status[2]));

  a_r1_done_after_work: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[0]) |-> $past(busy));
endmodule

bind uart_tx_engine utx_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_utx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .fifo_level(fifo_level),
  .busy      (busy),
  .txd       (txd),
  .abort_req (abort_req),
  .irq_status(irq_status)
);

// File: tb/uart_tx_engine_bench.sv
`timescale 1ns/1ps
module uart_tx_engine_bench;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [23:0] trans_len = '0;
  logic        cancel_req = 1'b0;
  logic        abort_req = 1'b0;
  logic [9:0]  cfg_word_len = 10'd8;
  logic        cfg_par_en = 1'b0;
  logic [1:0]  cfg_par_mode = '0;
  logic [1:0]  cfg_stop_len = '0;
  logic        cfg_cts_mask = 1'b1;
  logic [15:0] cfg_clk_div = 16'd1;
  logic [2:0]  cfg_bytes_per_word = 3'd1;
  logic [4:0]  cfg_watermark = 5'd2;
  logic        cts = 1'b1;
  logic [3:0]  irq_clear = '0;
  logic [3:0]  irq_status;
  logic [4:0]  fifo_level;
  logic        busy;
  logic        txd;

  uart_tx_engine u_uart_tx_engine (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // line monitor
  bit          mon_en = 1'b1;
  int          mon_nbits = 8;
  bit          mon_pe = 1'b0;
  int          bit_ns = 32 * CLK_NS;
  int          rx_cnt = 0;
  logic [7:0]  rx_data [64];
  logic        rx_par  [64];
  logic        rx_ok   [64];
  longint      rx_t    [64];

  initial begin
    forever begin
      @(negedge txd);
      if (mon_en) begin
        longint t0;
        logic [7:0] d;
        logic p, s0, s1;
        t0 = $time;
        d = '0;
        p = 1'b0;
        #(bit_ns/2);
        s0 = txd;
        for (int b = 0; b < mon_nbits; b++) begin
          #(bit_ns);
          d[b] = txd;
        end
        if (mon_pe) begin
          #(bit_ns);
          p = txd;
        end
        #(bit_ns);
        s1 = txd;
        rx_data[rx_cnt % 64] = d;
        rx_par[rx_cnt % 64]  = p;
        rx_ok[rx_cnt % 64]   = !s0 && s1;
        rx_t[rx_cnt % 64]    = t0;
        rx_cnt++;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic command(input logic [3:0] op, input int len);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    trans_len = 24'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk);
    irq_clear = m;
    @(negedge clk);
    irq_clear = '0;
  endtask

  task automatic wait_stat(input int b, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq_status[b]) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int mode);
    case (mode)
      0: return ^d;
      1: return ~^d;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int stop_t(input int sl);
    return (sl == 0) ? 32 : (sl == 1) ? 48 : 64;
  endfunction

  task automatic set_div(input int dv);
    cfg_clk_div = 16'(dv);
    bit_ns = 32 * ((dv == 0) ? 1 : dv) * CLK_NS;
  endtask

  initial begin
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R5", "idle txd", txd, 1);
    chk("R9", "reset level", fifo_level, 0);
    chk("R9", "reset ready", wr_ready, 1);
    chk("R10", "reset status low fill only", irq_status, 4'b1000);

    // R2 R3 R4: sweep word length, parity and stop length
    set_div(1);
    cfg_bytes_per_word = 3'd2;
    for (int wl = 5; wl <= 8; wl++) begin
      for (int pm = 0; pm <= 4; pm++) begin
        for (int sl = 0; sl <= 2; sl++) begin
          logic [7:0] b0, b1, mk;
          int pe;
          pe = (pm < 4) ? 1 : 0;
          cfg_word_len = 10'(wl);
          cfg_par_en   = pe[0];
          cfg_par_mode = 2'(pm);
          cfg_stop_len = 2'(sl);
          mon_nbits = wl;
          mon_pe = pe[0];
          mk = 8'hFF >> (8 - wl);
          b0 = 8'(wl * 29 + pm * 7 + sl * 3 + 8'h5A);
          b1 = ~b0 ^ 8'(pm * 19 + sl);
          rx_cnt = 0;
          push({16'hC3C3, b1, b0});
          command(4'd1, 2);
          wait_stat(0, 3000, ok);
          chk("R1", "sweep done", ok, 1);
          chk("R1", "sweep count", rx_cnt, 2);
          chk("R2", "sweep byte0", rx_data[0], b0 & mk);
          chk("R2", "sweep byte1", rx_data[1], b1 & mk);
          chk("R2", "sweep framing", rx_ok[0] && rx_ok[1], 1);
          if (pe != 0) begin
            chk("R3", "sweep parity0", rx_par[0], exp_par(b0 & mk, pm));
            chk("R3", "sweep parity1", rx_par[1], exp_par(b1 & mk, pm));
          end
          chk("R4", "sweep frame spacing", rx_t[1] - rx_t[0],
              longint'(((1 + wl + pe) * 32 + stop_t(sl)) * CLK_NS));
          chk("R7", "sweep fifo drained", fifo_level, 0);
          clr(4'b0111);
        end
      end
    end

    // R2 word-length clamping
    cfg_par_en = 1'b0;
    cfg_stop_len = 2'd0;
    cfg_bytes_per_word = 3'd1;
    cfg_word_len = 10'd3;
    mon_nbits = 5;
    mon_pe = 1'b0;
    rx_cnt = 0;
    push(32'h000000FF);
    push(32'h000000EA);
    command(4'd1, 2);
    wait_stat(0, 3000, ok);
    chk("R2", "short length clamps to 5 data", rx_data[1], 8'h0A);
    chk("R2", "5-bit spacing", rx_t[1] - rx_t[0], longint'(((1 + 5) * 32 + 32) * CLK_NS));
    clr(4'b0111);
    cfg_word_len = 10'd300;
    mon_nbits = 8;
    rx_cnt = 0;
    push(32'h000000A7);
    push(32'h0000005C);
    command(4'd1, 2);
    wait_stat(0, 3000, ok);
    chk("R2", "long length clamps to 8 data", rx_data[1], 8'h5C);
    chk("R2", "8-bit spacing", rx_t[1] - rx_t[0], longint'(320 * CLK_NS));
    clr(4'b0111);
    cfg_word_len = 10'd8;

    // R4 divider values 3 and 0
    for (int k = 0; k < 2; k++) begin
      int dv;
      dv = (k == 0) ? 3 : 0;
      set_div(dv);
      rx_cnt = 0;
      push(32'h00000031);
      push(32'h00000032);
      command(4'd1, 2);
      wait_stat(0, 6000, ok);
      chk("R4", "divider spacing", rx_t[1] - rx_t[0],
          longint'(320 * ((dv == 0) ? 1 : dv) * CLK_NS));
      chk("R4", "divider data", rx_data[1], 8'h32);
      clr(4'b0111);
    end
    set_div(1);

    // R1 zero length and exact count with extra words queued
    rx_cnt = 0;
    command(4'd1, 0);
    wait_stat(0, 200, ok);
    chk("R1", "zero length done", ok, 1);
    repeat (50) @(negedge clk);
    chk("R1", "zero length sends nothing", rx_cnt, 0);
    clr(4'b0111);
    push(32'h11); push(32'h22); push(32'h33);
    command(4'd1, 2);
    wait_stat(0, 3000, ok);
    chk("R1", "exact count", rx_cnt, 2);
    chk("R1", "extra word kept", fifo_level, 1);
    clr(4'b0111);
    rx_cnt = 0;
    command(4'd1, 1);
    wait_stat(0, 3000, ok);
    chk("R1", "leftover word sent", rx_data[0], 8'h33);
    clr(4'b0111);

    // R7 byte unpacking: three bytes per word, seven characters
    cfg_bytes_per_word = 3'd3;
    rx_cnt = 0;
    push(32'hEE030201);
    push(32'hEE060504);
    push(32'hEEEEEE07);
    command(4'd1, 7);
    wait_stat(0, 6000, ok);
    chk("R7", "3-per-word count", rx_cnt, 7);
    for (int i = 0; i < 7; i++) chk("R7", "3-per-word order", rx_data[i], i + 1);
    chk("R7", "partial word released", fifo_level, 0);
    clr(4'b0111);
    cfg_bytes_per_word = 3'd4;
    rx_cnt = 0;
    push(32'hDDCC4241);
    command(4'd1, 2);
    wait_stat(0, 3000, ok);
    chk("R7", "4-per-word short count", rx_cnt, 2);
    chk("R7", "4-per-word second byte", rx_data[1], 8'h42);
    chk("R7", "unused bytes dropped", fifo_level, 0);
    clr(4'b0111);
    cfg_bytes_per_word = 3'd0;
    rx_cnt = 0;
    push(32'h00007F61);
    push(32'h00007F62);
    command(4'd1, 2);
    wait_stat(0, 3000, ok);
    chk("R7", "zero per word acts as one", rx_data[1], 8'h62);
    clr(4'b0111);
    cfg_bytes_per_word = 3'd1;

    // R9 full FIFO and R10 watermark
    for (int i = 0; i < 16; i++) push(32'h40 + i);
    chk("R9", "full level", fifo_level, 16);
    chk("R9", "ready low when full", wr_ready, 0);
    push(32'h99);
    chk("R9", "write refused when full", fifo_level, 16);
    clr(4'b1000);
    chk("R13", "low fill cleared above threshold", irq_status[3], 0);
    repeat (10) @(negedge clk);
    chk("R10", "low fill stays clear", irq_status[3], 0);
    rx_cnt = 0;
    command(4'd1, 16);
    wait_stat(0, 8000, ok);
    chk("R9", "all 16 sent", rx_cnt, 16);
    chk("R9", "last word intact", rx_data[15], 8'h4F);
    chk("R10", "low fill set after drain", irq_status[3], 1);
    clr(4'b1111);
    cfg_watermark = 5'd5;
    for (int i = 0; i < 6; i++) push(32'h50 + i);
    clr(4'b1000);
    chk("R10", "level 6 above 5", irq_status[3], 0);
    command(4'd1, 1);
    wait_stat(0, 3000, ok);
    chk("R10", "level 5 at threshold sets bit", irq_status[3], 1);
    chk("R10", "level after one", fifo_level, 5);
    clr(4'b0001);
    chk("R13", "clear done only", irq_status, 4'b1000);
    command(4'd1, 5);
    wait_stat(0, 5000, ok);
    clr(4'b0111);
    cfg_watermark = 5'd2;

    // R6 clear to send
    cfg_cts_mask = 1'b0;
    cts = 1'b0;
    rx_cnt = 0;
    push(32'h77);
    command(4'd1, 1);
    repeat (1500) @(negedge clk);
    chk("R6", "held by cts", rx_cnt, 0);
    chk("R6", "line high while held", txd, 1);
    chk("R6", "busy while held", busy, 1);
    cts = 1'b1;
    wait_stat(0, 3000, ok);
    chk("R6", "sent after cts", rx_data[0], 8'h77);
    clr(4'b0111);
    cfg_cts_mask = 1'b1;
    cts = 1'b0;
    rx_cnt = 0;
    push(32'h78);
    command(4'd1, 1);
    wait_stat(0, 3000, ok);
    chk("R6", "mask ignores cts", rx_cnt, 1);
    clr(4'b0111);
    cts = 1'b1;

    // R8 break
    mon_en = 1'b0;
    command(4'd7, 3);
    chk("R8", "unknown opcode ignored", busy, 0);
    command(4'd5, 0);
    repeat (3) @(negedge clk);
    chk("R8", "stop without break ignored", irq_status[0], 0);
    command(4'd4, 0);
    repeat (500) @(negedge clk);
    chk("R8", "break holds low", txd, 0);
    chk("R8", "break busy", busy, 1);
    command(4'd5, 0);
    chk("R8", "break released", txd, 1);
    chk("R8", "break end done", irq_status[0], 1);
    clr(4'b0111);
    repeat (5) @(negedge clk);
    mon_en = 1'b1;

    // R11 cancel at a character boundary
    rx_cnt = 0;
    for (int i = 0; i < 4; i++) push(32'h60 + i);
    command(4'd1, 4);
    @(negedge txd);
    repeat (100) @(negedge clk);
    cancel_req = 1'b1;
    @(negedge clk);
    cancel_req = 1'b0;
    wait_stat(1, 3000, ok);
    chk("R11", "cancel done", ok, 1);
    chk("R11", "one char finished", rx_cnt, 1);
    chk("R11", "first char intact", rx_data[0], 8'h60);
    chk("R11", "no done on cancel", irq_status[0], 0);
    chk("R11", "words kept", fifo_level, 3);
    clr(4'b0111);
    command(4'd1, 3);
    wait_stat(0, 5000, ok);
    chk("R11", "rest sent later", rx_cnt, 4);
    clr(4'b0111);
    @(negedge clk);
    cancel_req = 1'b1;
    @(negedge clk);
    cancel_req = 1'b0;
    chk("R11", "idle cancel", irq_status[1], 1);
    clr(4'b0111);

    // R12 abort mid character
    rx_cnt = 0;
    push(32'h81);
    push(32'h82);
    command(4'd1, 2);
    @(negedge txd);
    repeat (40) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk("R12", "abort idle", busy, 0);
    chk("R12", "abort line high", txd, 1);
    chk("R12", "abort flag", irq_status[2], 1);
    repeat (600) @(negedge clk);
    chk("R12", "second word kept", fifo_level, 1);
    clr(4'b0111);
    rx_cnt = 0;
    command(4'd1, 1);
    wait_stat(0, 3000, ok);
    chk("R12", "resume after abort", rx_data[0], 8'h82);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule